// File: doc/BRIEF.md
# Shared-Memory Power-Cap Mailbox Engine

This engine serves a command mailbox held in a small shared buffer. A free-running prescaler produces a poll tick every `tick_period_i + 1` clock cycles. On each tick the engine reads the command header and the response flag through a synchronous byte-wide memory port. Software posts a request by filling in the command area and then writing the ready code to the command flag byte. A request that arrives with a cleared response flag first gets a one-tick "in progress" acknowledgement. It is executed on the next tick.

The only command carried out is a power-limit update. A zero request removes the cap. A non-zero request is clamped to the hard-minimum/maximum window. Every answer echoes the request token and the opcode, then a status byte, a big-endian length and an optional 2-byte payload. The flag handover comes after these bytes: the response flag is set to done, then the command flag is cleared, and then a one-cycle message-interrupt request is raised. After reset the engine fills a status area with the power-management defaults.

Top module: `mbox_engine`

## Requirements
- R1: After reset the engine writes the status area (base STAT): +0 state 0x03, +1 cap type 0x00, +2/+3 hard minimum 10, +4/+5 maximum 100, +6/+7 current limit 100, +8/+9 soft minimum 20. Every 16-bit field is big-endian, high byte first.
- R2: A poll acts only when the command flag (command area +0) equals exactly 0x80. For any other value nothing is written and no interrupt request is raised.
- R3: If the response flag (response area +0) is 0x00 when a ready command is seen, the engine writes only 0x02 to the response flag on that tick. The command flag stays 0x80 and no interrupt is raised.
- R4: If the response flag is neither 0x00 nor 0x02, the engine answers at once with status 0x15 and length 0.
- R5: Opcode 0xD1 with a length field (command +4/+5) other than 2 is answered with status 0x12, length 2 and the current limit as payload. The limit does not change.
- R6: Opcode 0xD1 with length 2 and request value 0 (command +6/+7) sets the cap type to 0x00 and the current limit to 100. It answers status 0x00, length 2, payload 100.
- R7: Opcode 0xD1 with length 2 and a non-zero request sets the cap type to 0x02. The limit becomes the request clamped to 10..100, is written to status +6/+7, and is answered with status 0x00, length 2 and the limit as payload.
- R8: Any other opcode is answered with status 0x11 and length 0.
- R9: Every answer copies the request token (command +1) to response +1 and the opcode (command +2) to response +2. Status goes to response +3, length to +4/+5 and payload to +6/+7.
- R10: All response and status bytes are written before the response flag is set to 0x01. The command flag is then cleared to 0x00 on the next cycle, followed by exactly one single-cycle interrupt-request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_period_i | input | TW | Poll interval minus one, in clock cycles |
| mem_addr_o | output | AW | Byte address into the shared buffer |
| mem_re_o | output | 1 | Read strobe; data returns on the following cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after the strobe |
| irq_o | output | 1 | One-cycle message-interrupt request |

## Verification
The bench targets the flag handshake first. A design that skipped the in-progress tick would answer on the first poll. A design that did not flag an inconsistent response flag (a leftover 0x01 or a stray 0x05) would hang or execute the request instead of returning the internal-error status. The clamp boundaries (5, 10, 100, 300) and the zero-means-clear rule are driven one after another, so a swapped comparison or a missing cap-type change shows up as a wrong payload or a wrong status byte. A bad-length request is sent after the limit has moved away from 100; an engine that returned the maximum instead of the stored limit would be caught. A non-ready flag code of 0x81 checks that a loose bit test is not used in place of an exact match.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [2:0] {
        S_INIT,
        S_IDLE,
        S_READ,
        S_DECIDE,
        S_PROG,
        S_WRSP,
        S_WFLG,
        S_IRQ
    } mbox_state_e;

    localparam logic [7:0] CFLAG_READY = 8'h80;
    localparam logic [7:0] RFLAG_IDLE  = 8'h00;
    localparam logic [7:0] RFLAG_BUSY  = 8'h02;
    localparam logic [7:0] RFLAG_DONE  = 8'h01;
    localparam logic [7:0] OP_SET_CAP  = 8'hD1;

    localparam logic [7:0] ST_OK       = 8'h00;
    localparam logic [7:0] ST_BAD_OP   = 8'h11;
    localparam logic [7:0] ST_BAD_LEN  = 8'h12;
    localparam logic [7:0] ST_INTERNAL = 8'h15;

    localparam logic [7:0] CAPT_NONE   = 8'h00;
    localparam logic [7:0] CAPT_USER   = 8'h02;
    localparam logic [7:0] STATE_ACTIVE = 8'h03;

endpackage

// File: rtl/mbox_tick.sv
module mbox_tick #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] period_i,
    output logic          tick_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q >= period_i);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/mbox_cap_clamp.sv
module mbox_cap_clamp
    import mbox_pkg::*;
#(
    parameter int LIM_MAX  = 100,
    parameter int LIM_HARD = 10
) (
    input  logic [15:0] req_i,
    output logic [15:0] lim_o,
    output logic [7:0]  capt_o
);
    localparam logic [15:0] MAX16  = 16'(LIM_MAX);
    localparam logic [15:0] HARD16 = 16'(LIM_HARD);

    always_comb begin
        if (req_i == 16'd0) begin
            lim_o  = MAX16;
            capt_o = CAPT_NONE;
        end else begin
            capt_o = CAPT_USER;
            if (req_i < HARD16)     lim_o = HARD16;
            else if (req_i > MAX16) lim_o = MAX16;
            else                    lim_o = req_i;
        end
    end
endmodule

// File: rtl/mbox_engine.sv
module mbox_engine
    import mbox_pkg::*;
#(
    parameter int AW        = 6,
    parameter int TW        = 16,
    parameter int CMD_BASE  = 0,
    parameter int RSP_BASE  = 16,
    parameter int STAT_BASE = 32,
    parameter int LIM_MAX   = 100,
    parameter int LIM_HARD  = 10,
    parameter int LIM_SOFT  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tick_period_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_re_o,
    output logic          mem_we_o,
    output logic [7:0]    mem_wdata_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          irq_o
);
    localparam logic [AW-1:0] A_CMD  = AW'(CMD_BASE);
    localparam logic [AW-1:0] A_RSP  = AW'(RSP_BASE);
    localparam logic [AW-1:0] A_STAT = AW'(STAT_BASE);
    localparam logic [15:0]   MAX16  = 16'(LIM_MAX);
    localparam logic [15:0]   HARD16 = 16'(LIM_HARD);
    localparam logic [15:0]   SOFT16 = 16'(LIM_SOFT);
    localparam logic [3:0]    LAST_INIT = 4'd9;
    localparam logic [3:0]    LAST_READ = 4'd9;
    localparam logic [3:0]    LAST_WRSP = 4'd9;

    typedef struct packed {
        mbox_state_e st;
        logic [3:0]  step;
        logic [7:0]  cflag;
        logic [7:0]  rid;
        logic [7:0]  op;
        logic [15:0] clen;
        logic [15:0] cdata;
        logic [7:0]  rflag;
        logic [7:0]  status;
        logic [15:0] rlen;
        logic [15:0] rdat;
        logic [15:0] cur;
        logic [7:0]  capt;
        logic        upd;
    } ctx_t;

    ctx_t        d, q;
    logic        tick;
    logic [15:0] clamp_lim;
    logic [7:0]  clamp_capt;
    logic [3:0]  cap_idx;

    mbox_tick #(.TW(TW)) i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (tick_period_i),
        .tick_o   (tick)
    );

    mbox_cap_clamp #(.LIM_MAX(LIM_MAX), .LIM_HARD(LIM_HARD)) i_clamp (
        .req_i  (q.cdata),
        .lim_o  (clamp_lim),
        .capt_o (clamp_capt)
    );

    function automatic logic [7:0] init_byte(input logic [3:0] k);
        case (k)
            4'd0:    return STATE_ACTIVE;
            4'd1:    return CAPT_NONE;
            4'd2:    return HARD16[15:8];
            4'd3:    return HARD16[7:0];
            4'd4:    return MAX16[15:8];
            4'd5:    return MAX16[7:0];
            4'd6:    return MAX16[15:8];
            4'd7:    return MAX16[7:0];
            4'd8:    return SOFT16[15:8];
            default: return SOFT16[7:0];
        endcase
    endfunction

    always_comb begin
        d           = q;
        mem_addr_o  = '0;
        mem_re_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = '0;
        irq_o       = 1'b0;
        cap_idx     = q.step - 4'd1;

        case (q.st)
            S_INIT: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = A_STAT + AW'(q.step);
                mem_wdata_o = init_byte(q.step);
                d.step      = q.step + 4'd1;
                if (q.step == LAST_INIT) begin
                    d.st   = S_IDLE;
                    d.step = '0;
                end
            end
            S_IDLE: begin
                if (tick) begin
                    d.st   = S_READ;
                    d.step = '0;
                end
            end
            S_READ: begin
                if (q.step < 4'd8) begin
                    mem_re_o   = 1'b1;
                    mem_addr_o = A_CMD + AW'(q.step);
                end else if (q.step == 4'd8) begin
                    mem_re_o   = 1'b1;
                    mem_addr_o = A_RSP;
                end
                if (q.step != 4'd0) begin
                    case (cap_idx)
                        4'd0:    d.cflag       = mem_rdata_i;
                        4'd1:    d.rid         = mem_rdata_i;
                        4'd2:    d.op          = mem_rdata_i;
                        4'd4:    d.clen[15:8]  = mem_rdata_i;
                        4'd5:    d.clen[7:0]   = mem_rdata_i;
                        4'd6:    d.cdata[15:8] = mem_rdata_i;
                        4'd7:    d.cdata[7:0]  = mem_rdata_i;
                        4'd8:    d.rflag       = mem_rdata_i;
                        default: ;
                    endcase
                end
                d.step = q.step + 4'd1;
                if (q.step == LAST_READ) begin
                    d.st   = S_DECIDE;
                    d.step = '0;
                end
            end
            S_DECIDE: begin
                d.upd  = 1'b0;
                d.step = '0;
                d.st   = S_WRSP;
                if (q.cflag != CFLAG_READY) begin
                    d.st = S_IDLE;
                end else if (q.rflag == RFLAG_IDLE) begin
                    d.st = S_PROG;
                end else if (q.rflag != RFLAG_BUSY) begin
                    d.status = ST_INTERNAL;
                    d.rlen   = '0;
                end else if (q.op == OP_SET_CAP) begin
                    d.rlen = 16'd2;
                    if (q.clen != 16'd2) begin
                        d.status = ST_BAD_LEN;
                        d.rdat   = q.cur;
                    end else begin
                        d.status = ST_OK;
                        d.rdat   = clamp_lim;
                        d.cur    = clamp_lim;
                        d.capt   = clamp_capt;
                        d.upd    = 1'b1;
                    end
                end else begin
                    d.status = ST_BAD_OP;
                    d.rlen   = '0;
                end
            end
            S_PROG: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = A_RSP;
                mem_wdata_o = RFLAG_BUSY;
                d.st        = S_IDLE;
            end
            S_WRSP: begin
                case (q.step)
                    4'd0: begin mem_we_o = 1'b1; mem_addr_o = A_RSP + AW'(1); mem_wdata_o = q.rid; end
                    4'd1: begin mem_we_o = 1'b1; mem_addr_o = A_RSP + AW'(2); mem_wdata_o = q.op; end
                    4'd2: begin mem_we_o = 1'b1; mem_addr_o = A_RSP + AW'(3); mem_wdata_o = q.status; end
                    4'd3: begin mem_we_o = 1'b1; mem_addr_o = A_RSP + AW'(4); mem_wdata_o = q.rlen[15:8]; end
                    4'd4: begin mem_we_o = 1'b1; mem_addr_o = A_RSP + AW'(5); mem_wdata_o = q.rlen[7:0]; end
                    4'd5: begin mem_we_o = (q.rlen != '0); mem_addr_o = A_RSP + AW'(6); mem_wdata_o = q.rdat[15:8]; end
                    4'd6: begin mem_we_o = (q.rlen != '0); mem_addr_o = A_RSP + AW'(7); mem_wdata_o = q.rdat[7:0]; end
                    4'd7: begin mem_we_o = q.upd; mem_addr_o = A_STAT + AW'(1); mem_wdata_o = q.capt; end
                    4'd8: begin mem_we_o = q.upd; mem_addr_o = A_STAT + AW'(6); mem_wdata_o = q.cur[15:8]; end
                    default: begin mem_we_o = q.upd; mem_addr_o = A_STAT + AW'(7); mem_wdata_o = q.cur[7:0]; end
                endcase
                d.step = q.step + 4'd1;
                if (q.step == LAST_WRSP) begin
                    d.st   = S_WFLG;
                    d.step = '0;
                end
            end
            S_WFLG: begin
                mem_we_o = 1'b1;
                if (q.step == 4'd0) begin
                    mem_addr_o  = A_RSP;
                    mem_wdata_o = RFLAG_DONE;
                    d.step      = 4'd1;
                end else begin
                    mem_addr_o  = A_CMD;
                    mem_wdata_o = 8'h00;
                    d.st        = S_IRQ;
                    d.step      = '0;
                end
            end
            S_IRQ: begin
                irq_o = 1'b1;
                d.st  = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_INIT;
            q.cur  <= MAX16;
            q.capt <= CAPT_NONE;
        end else begin
            q <= d;
        end
    end

    AST_CUR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cur >= HARD16) && (q.cur <= MAX16)); // R7
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R10
    AST_IRQ_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mem_we_o && mem_addr_o == A_CMD && mem_wdata_o == 8'h00)); // R10
    AST_DONE_THEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_addr_o == A_RSP && mem_wdata_o == RFLAG_DONE)
            |=> (mem_we_o && mem_addr_o == A_CMD && mem_wdata_o == 8'h00)); // R10
    AST_BUSY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_addr_o == A_RSP && mem_wdata_o == RFLAG_BUSY) |=> !irq_o); // R3
endmodule

// File: tb/test_mbox_engine.sv
module test_mbox_engine;
    localparam int CLK_PERIOD = 10;
    localparam int CMD  = 0;
    localparam int RSP  = 16;
    localparam int STAT = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] tick_period = 16'd31;
    logic [5:0] mem_addr;
    logic       mem_re, mem_we, irq;
    logic [7:0] mem_wdata, mem_rdata;
    logic [7:0] mem [64];
    logic       tb_we = 1'b0;
    logic [5:0] tb_addr = '0;
    logic [7:0] tb_wdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    int cur_m = 100;
    int capt_m = 0;

    typedef struct {
        string tag;
        int    rid;
        int    op;
        int    status;
        int    len;
        int    data;
        int    cur;
        int    capt;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_engine i_mbox_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_period_i (tick_period),
        .mem_addr_o    (mem_addr),
        .mem_re_o      (mem_re),
        .mem_we_o      (mem_we),
        .mem_wdata_o   (mem_wdata),
        .mem_rdata_i   (mem_rdata),
        .irq_o         (irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
            mem_rdata <= 8'h00;
        end else begin
            if (mem_re) mem_rdata <= mem[mem_addr];
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else if (tb_we) mem[tb_addr] <= tb_wdata;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = 6'(a); tb_wdata = 8'(v);
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    // monitor: pops expected answers when the interrupt request is seen
    always @(negedge clk) begin
        if (rst_n && irq) begin
            irq_cnt++;
            if (exp_q.size() == 0) begin
                check("R10 unexpected irq", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R9 request id", mem[RSP+1], e.rid);
                check("R9 opcode echo", mem[RSP+2], e.op);
                check({e.tag, " status"}, mem[RSP+3], e.status);
                check({e.tag, " length"}, {mem[RSP+4], mem[RSP+5]}, e.len);
                if (e.len == 2)
                    check({e.tag, " payload"}, {mem[RSP+6], mem[RSP+7]}, e.data);
                check("R10 response flag done", mem[RSP], 8'h01);
                check("R10 command flag cleared", mem[CMD], 8'h00);
                check({e.tag, " stored limit"}, {mem[STAT+6], mem[STAT+7]}, e.cur);
                check({e.tag, " cap type"}, mem[STAT+1], e.capt);
            end
        end
    end

    task automatic run_cmd(input int rid, input int op, input int len, input int data, input int rflag);
        exp_t e;
        int   base;
        e.rid = rid; e.op = op; e.len = 0; e.data = 0;
        if (rflag != 0 && rflag != 2) begin
            e.tag = "R4"; e.status = 'h15;
        end else if (op == 'hD1) begin
            e.len = 2;
            if (len != 2) begin
                e.tag = "R5"; e.status = 'h12; e.data = cur_m;
            end else begin
                e.status = 0;
                if (data == 0) begin
                    e.tag = "R6"; cur_m = 100; capt_m = 0;
                end else begin
                    e.tag = "R7"; capt_m = 2;
                    cur_m = (data < 10) ? 10 : (data > 100) ? 100 : data;
                end
                e.data = cur_m;
            end
        end else begin
            e.tag = "R8"; e.status = 'h11;
        end
        e.cur = cur_m; e.capt = capt_m;
        exp_q.push_back(e);
        base = irq_cnt;
        wr(RSP, rflag);
        wr(CMD+1, rid);
        wr(CMD+2, op);
        wr(CMD+4, len >> 8);
        wr(CMD+5, len & 'hFF);
        wr(CMD+6, data >> 8);
        wr(CMD+7, data & 'hFF);
        wr(CMD, 'h80);
        if (rflag == 0) begin
            for (int i = 0; i < 200 && mem[RSP] != 8'h02; i++) @(negedge clk);
            check("R3 busy flag written", mem[RSP], 8'h02);
            check("R3 no irq on busy tick", irq_cnt, base);
            check("R3 command flag kept", mem[CMD], 8'h80);
        end
        for (int i = 0; i < 300 && irq_cnt == base; i++) @(negedge clk);
        check("R10 one irq per answer", irq_cnt, base + 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (15) @(negedge clk);
        check("R1 state", mem[STAT], 8'h03);
        check("R1 cap type", mem[STAT+1], 8'h00);
        check("R1 hard min", {mem[STAT+2], mem[STAT+3]}, 10);
        check("R1 maximum", {mem[STAT+4], mem[STAT+5]}, 100);
        check("R1 current", {mem[STAT+6], mem[STAT+7]}, 100);
        check("R1 soft min", {mem[STAT+8], mem[STAT+9]}, 20);

        // R2: a flag code other than 0x80 is ignored
        begin
            int base;
            base = irq_cnt;
            wr(RSP, 0);
            wr(CMD+2, 'hD1);
            wr(CMD, 'h81);
            repeat (100) @(negedge clk);
            check("R2 response flag untouched", mem[RSP], 8'h00);
            check("R2 no irq", irq_cnt, base);
            check("R2 command flag untouched", mem[CMD], 8'h81);
            wr(CMD, 0);
        end

        run_cmd('h11, 'hD1, 2, 50, 0);
        run_cmd('h22, 'hD1, 3, 77, 0);
        run_cmd('h33, 'hD1, 2, 5, 0);
        run_cmd('h44, 'hD1, 2, 300, 0);
        run_cmd('h55, 'hD1, 2, 10, 0);
        run_cmd('h66, 'hD1, 2, 100, 0);
        run_cmd('h77, 'hD1, 2, 64, 0);
        run_cmd('h88, 'hD1, 2, 0, 0);
        run_cmd('h99, 'h42, 2, 30, 0);
        run_cmd('hA1, 'hD1, 2, 40, 5);
        run_cmd('hA2, 'hD1, 2, 40, 1);
        check("R4 limit unchanged after error", {mem[STAT+6], mem[STAT+7]}, 100);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule